// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses the next control-memory address in a microprogrammed control unit. It holds a 7-bit control address register (`car`), which indexes a 128-word control store. It also holds a one-deep return register for micro-subroutines. On each cycle the control store supplies the current microinstruction's condition select, branch type and address field. The sequencer combines these with three status inputs and the 4-bit opcode of the machine instruction being executed. From them it forms the next address.

The next address is one of four values: `car + 1`, the microinstruction's address field, the saved return address, or the routine entry for the opcode. The entry for opcode `b3 b2 b1 b0` is the 7-bit value `0 b3 b2 b1 b0 0 0`, so the sixteen routine entries fall on multiples of four between 0 and 60. Reset points the register at word 64, where the fetch routine starts. The choice logic is combinational, and both registers update on the rising clock edge.

Top module: `usq_sequencer`

## Requirements
- R1: While reset is asserted, `car` is 64 and the return register is 0. A return issued as the first step after reset therefore goes to address 0.
- R2: With branch type 00 (jump), a true condition loads `addr_field` into `car`. A false condition loads `car + 1`.
- R3: Condition select 00 is always true, whatever the values of the three status inputs.
- R4: Condition select 01 tests `st_indirect`, 10 tests `st_sign` and 11 tests `st_zero`. The two status inputs that are not selected have no effect on the next address.
- R5: With branch type 01 (call), a true condition loads `addr_field` into `car` and stores `car + 1` in the return register. A false condition increments `car` and leaves the return register unchanged.
- R6: With branch type 10 (return), `car` is loaded from the return register whatever the condition result.
- R7: With branch type 11 (map), `car` is loaded with `{1'b0, opcode, 2'b00}` whatever the condition result.
- R8: Incrementing from 127 gives 0.
- R9: The return register holds one level only. A second taken call replaces the saved address, and every later return goes to the most recent one.
- R10: A taken call made at address 127 saves 0 as the return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| cond_sel | input | 2 | Condition select: 00 always, 01 indirect, 10 sign, 11 zero |
| br_type | input | 2 | Branch type: 00 jump, 01 call, 10 return, 11 map |
| addr_field | input | 7 | Branch target from the microinstruction |
| opcode | input | 4 | Opcode of the current machine instruction |
| st_indirect | input | 1 | Indirect-address bit of the instruction |
| st_sign | input | 1 | Sign bit of the accumulator |
| st_zero | input | 1 | Accumulator-is-zero flag |
| car | output | 7 | Current control-memory address |

## Verification
On every cycle the assertions check the transition rules for each branch type. These are: the jump target when the condition holds, the increment when it fails, return and map targets, the save of `car + 1` on a taken call, and the return register holding steady at all other times. They also check that condition select 00 always yields a true condition. The bench scenarios cover what a single-cycle property cannot show. These are the reset address and cleared return register, which status input is actually tested and that the other two are ignored, wrap-around at 127, and the overwriting of the return register by nested calls, seen through later returns.

// File: rtl/usq_pkg.sv
package usq_pkg;

  typedef enum logic [1:0] {
    COND_ALWAYS = 2'b00,
    COND_IND    = 2'b01,
    COND_SIGN   = 2'b10,
    COND_ZERO   = 2'b11
  } cond_e;

  typedef enum logic [1:0] {
    BR_JUMP   = 2'b00,
    BR_CALL   = 2'b01,
    BR_RETURN = 2'b10,
    BR_MAP    = 2'b11
  } br_e;

endpackage

// File: rtl/usq_cond_sel.sv
module usq_cond_sel #(
  parameter int NSTAT = 3,
  localparam int SELW = $clog2(NSTAT + 1)
) (
  input  logic [SELW-1:0]  sel,
  input  logic [NSTAT-1:0] status,
  output logic             hit
);

  // Slot 0 is tied high so that select 0 is an unconditional test.
  logic [NSTAT:0] pool;

  always_comb begin
    pool = {status, 1'b1};
    hit  = pool[sel];
  end

endmodule

// File: rtl/usq_next_addr.sv
module usq_next_addr
  import usq_pkg::*;
#(
  parameter int AW  = 7,
  parameter int OPW = 4,
  localparam int PAD = AW - OPW - 1
) (
  input  logic [AW-1:0]  car,
  input  br_e            br,
  input  logic           hit,
  input  logic [AW-1:0]  addr_field,
  input  logic [OPW-1:0] opcode,
  input  logic [AW-1:0]  ret_q,
  output logic [AW-1:0]  car_nxt,
  output logic [AW-1:0]  car_inc,
  output logic           ret_load
);

  logic [AW-1:0] map_addr;

  generate
    if (PAD > 0) begin : g_pad
      assign map_addr = {1'b0, opcode, {PAD{1'b0}}};
    end else begin : g_nopad
      assign map_addr = {1'b0, opcode};
    end
  endgenerate

  always_comb begin
    car_inc  = car + AW'(1);
    ret_load = 1'b0;
    car_nxt  = car_inc;
    unique case (br)
      BR_JUMP:   if (hit) car_nxt = addr_field;
      BR_CALL:   if (hit) begin
                   car_nxt  = addr_field;
                   ret_load = 1'b1;
                 end
      BR_RETURN: car_nxt = ret_q;
      BR_MAP:    car_nxt = map_addr;
      default:   car_nxt = car_inc;
    endcase
  end

endmodule

// File: rtl/usq_ret_reg.sv
module usq_ret_reg #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] q
);

  logic [AW-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/usq_sequencer.sv
module usq_sequencer
  import usq_pkg::*;
#(
  parameter int AW          = 7,
  parameter int OPW         = 4,
  parameter int FETCH_ENTRY = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cond_sel,
  input  logic [1:0]     br_type,
  input  logic [AW-1:0]  addr_field,
  input  logic [OPW-1:0] opcode,
  input  logic           st_indirect,
  input  logic           st_sign,
  input  logic           st_zero,
  output logic [AW-1:0]  car
);

  localparam int NSTAT = 3;
  localparam logic [AW-1:0] RST_CAR = AW'(FETCH_ENTRY);

  br_e           br;
  logic          hit;
  logic          ret_load;
  logic [AW-1:0] ret_q;
  logic [AW-1:0] car_nxt;
  logic [AW-1:0] car_inc;

  assign br = br_e'(br_type);

  usq_cond_sel #(.NSTAT(NSTAT)) u_cond (
    .sel    (cond_sel),
    .status ({st_zero, st_sign, st_indirect}),
    .hit    (hit)
  );

  usq_next_addr #(.AW(AW), .OPW(OPW)) u_next (
    .car        (car),
    .br         (br),
    .hit        (hit),
    .addr_field (addr_field),
    .opcode     (opcode),
    .ret_q      (ret_q),
    .car_nxt    (car_nxt),
    .car_inc    (car_inc),
    .ret_load   (ret_load)
  );

  usq_ret_reg #(.AW(AW)) u_ret (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ret_load),
    .din   (car_inc),
    .q     (ret_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) car <= RST_CAR;
    else        car <= car_nxt;
  end

  // R3: select 00 must always produce a true condition
  p_always_true_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 2'b00) |-> hit);

  // R2: a taken jump lands on the address field
  p_jump_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_type == 2'b00 && hit) |=> (car == $past(addr_field)));

  // R2 and R5: a failed jump or call steps forward by one
  p_step_on_false_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_type[1] == 1'b0 && !hit) |=> (car == AW'($past(car) + AW'(1))));

  // R5: a taken call saves the address after the calling one
  p_call_saves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_type == 2'b01 && hit) |=> (ret_q == AW'($past(car) + AW'(1))));

  // R5 and R9: the return register is written only by a taken call
  p_ret_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_type == 2'b01 && hit) |=> $stable(ret_q));

  // R6: a return reloads from the saved address
  p_return_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_type == 2'b10) |=> (car == $past(ret_q)));

  // R7: map goes to the opcode routine entry
  p_map_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_type == 2'b11) |=> (car[AW-1] == 1'b0 && car[1:0] == 2'b00 &&
                            car[OPW+1:2] == $past(opcode)));

endmodule

// File: tb/usq_sequencer_tb.sv
module usq_sequencer_tb;

  typedef struct {
    logic [6:0] exp;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cond_sel = 2'b00;
  logic [1:0] br_type = 2'b00;
  logic [6:0] addr_field = '0;
  logic [3:0] opcode = '0;
  logic       st_indirect = 1'b0;
  logic       st_sign = 1'b0;
  logic       st_zero = 1'b0;
  logic [6:0] car;

  int n_checks = 0;
  int n_fail = 0;
  item_t sb_q[$];

  logic [6:0] m_car;
  logic [6:0] m_ret;

  always #2.5 clk = ~clk;

  usq_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel), .br_type(br_type),
    .addr_field(addr_field), .opcode(opcode), .st_indirect(st_indirect),
    .st_sign(st_sign), .st_zero(st_zero), .car(car)
  );

  task automatic check(input logic [6:0] act, input logic [6:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: car=%0d expected %0d", req, act, exp);
    end
  endtask

  // driver: applies one microinstruction and queues the expected next address
  task automatic apply(input logic [1:0] c, input logic [1:0] b, input logic [6:0] ad,
                       input logic [3:0] op, input logic si, input logic ss,
                       input logic sz, input string req);
    logic       t;
    logic [6:0] inc;
    item_t      it;
    @(negedge clk);
    cond_sel = c; br_type = b; addr_field = ad; opcode = op;
    st_indirect = si; st_sign = ss; st_zero = sz;
    case (c)
      2'b00: t = 1'b1;
      2'b01: t = si;
      2'b10: t = ss;
      default: t = sz;
    endcase
    inc = m_car + 7'd1;
    case (b)
      2'b00: m_car = t ? ad : inc;
      2'b01: begin
        if (t) begin m_ret = inc; m_car = ad; end
        else m_car = inc;
      end
      2'b10: m_car = m_ret;
      default: m_car = {1'b0, op, 2'b00};
    endcase
    it.exp = m_car;
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compares each result just after the edge that produces it
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(car, it.exp, it.req);
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    m_car = 7'd64;
    m_ret = 7'd0;
    repeat (3) @(negedge clk);
    check(car, 7'd64, "R1 reset address");
    rst_n = 1'b1;
    // R1: return register cleared, so a return goes to 0
    apply(2'b11, 2'b10, 7'd99, 4'd0, 1'b0, 1'b0, 1'b0, "R1 R6 return after reset");
    // R3: unconditional with all status low
    apply(2'b00, 2'b00, 7'd100, 4'd0, 1'b0, 1'b0, 1'b0, "R3 unconditional jump");
    // R2 and R4: indirect test
    apply(2'b01, 2'b00, 7'd5, 4'd0, 1'b0, 1'b1, 1'b1, "R2 R4 indirect false increments");
    apply(2'b01, 2'b00, 7'd20, 4'd0, 1'b1, 1'b0, 1'b0, "R4 indirect true jumps");
    apply(2'b10, 2'b00, 7'd70, 4'd0, 1'b1, 1'b0, 1'b1, "R4 sign false ignores others");
    apply(2'b10, 2'b00, 7'd30, 4'd0, 1'b0, 1'b1, 1'b0, "R4 sign true jumps");
    apply(2'b11, 2'b00, 7'd40, 4'd0, 1'b0, 1'b0, 1'b1, "R4 zero true jumps");
    apply(2'b11, 2'b00, 7'd9, 4'd0, 1'b1, 1'b1, 1'b0, "R4 zero false ignores others");
    // R5: call taken and not taken, then return
    apply(2'b00, 2'b01, 7'd90, 4'd0, 1'b0, 1'b0, 1'b0, "R5 taken call");
    apply(2'b11, 2'b01, 7'd3, 4'd0, 1'b0, 1'b0, 1'b0, "R5 untaken call increments");
    apply(2'b11, 2'b10, 7'd3, 4'd0, 1'b0, 1'b0, 1'b0, "R5 R6 return to saved");
    // R9: nested calls overwrite
    apply(2'b00, 2'b01, 7'd10, 4'd0, 1'b0, 1'b0, 1'b0, "R9 first call");
    apply(2'b00, 2'b01, 7'd50, 4'd0, 1'b0, 1'b0, 1'b0, "R9 second call");
    apply(2'b00, 2'b10, 7'd0, 4'd0, 1'b0, 1'b0, 1'b0, "R9 return to latest");
    apply(2'b00, 2'b10, 7'd0, 4'd0, 1'b0, 1'b0, 1'b0, "R9 repeated return");
    // R7: every opcode maps, with a false condition
    for (int op = 0; op < 16; op++)
      apply(2'b10, 2'b11, 7'd127, 4'(op), 1'b0, 1'b0, 1'b0, "R7 opcode map");
    // R8: wrap on increment
    apply(2'b00, 2'b00, 7'd126, 4'd0, 1'b0, 1'b0, 1'b0, "R8 jump near top");
    apply(2'b01, 2'b00, 7'd1, 4'd0, 1'b0, 1'b0, 1'b0, "R8 step to 127");
    apply(2'b01, 2'b00, 7'd1, 4'd0, 1'b0, 1'b0, 1'b0, "R8 wrap to 0");
    // R10: call from 127 saves 0
    apply(2'b00, 2'b00, 7'd127, 4'd0, 1'b0, 1'b0, 1'b0, "R10 jump to 127");
    apply(2'b00, 2'b01, 7'd5, 4'd0, 1'b0, 1'b0, 1'b0, "R10 call from 127");
    apply(2'b01, 2'b10, 7'd0, 4'd0, 1'b0, 1'b0, 1'b0, "R10 return wraps to 0");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule